// File: doc/BRIEF.md
# Processor Halt and Wake Controller

This block holds the halt state of a small 16-bit processor core. When the core retires a halt instruction, it raises `halt_req` together with the address of the next instruction. The controller then stops fetch and execution by asserting `halted`. It also keeps the local bus idle through `bus_grant_inhibit`, and it stores that address as the return pointer for the interrupt entry logic.

The core leaves halt on one of three events:
- a rising edge on the non-maskable interrupt line,
- a maskable interrupt level while the interrupt-enable flag is set,
- a synchronous reset.

On every exit, a one-cycle wake pulse and a two-bit cause code go to the interrupt entry logic. The return pointer stays frozen so that the handler resumes after the halt instruction.

The state machine has two states. `ST_RUN` is the core executing. `ST_HALT` is the core stopped. There are two transitions:
- `T_ENTER`: `ST_RUN` to `ST_HALT` when `halt_req` is sampled.
- `T_WAKE`: `ST_HALT` to `ST_RUN` when a wake event is sampled.

Reset forces `ST_RUN` from either state.

Top module: `halt_wake_ctrl`

## Requirements
- R1: With `halted` low, a clock edge that samples `halt_req`=1 sets `halted` after that edge and loads `ret_ip` with `next_ip`.
- R2: `bus_grant_inhibit` is 1 in exactly the cycles where `halted` is 1.
- R3: While halted, a clock edge that samples a rising edge of `nmi` (1 now, 0 at the previous edge) clears `halted` after that edge and sets `wake_cause` to 2'b10.
- R4: While halted, `intr`=1 with `if_flag`=1 clears `halted` after the edge and sets `wake_cause` to 2'b11. With `if_flag`=0, the core stays halted. While running, `intr` has no effect.
- R5: `rst`=1 at a clock edge clears `halted`, clears `ret_ip` to 0 and sets `wake_cause` to 2'b01, whatever the other inputs are.
- R6: `ret_ip` keeps the `next_ip` captured at halt entry for the whole halt and through the wake cycle.
- R7: When several wake events are sampled at the same edge, the priority is reset, then NMI, then maskable interrupt.
- R8: `wake_pulse` is 1 for exactly one cycle after each edge that leaves `ST_HALT`, and is 0 otherwise.
- R9: An `nmi` level that is already high when the halt starts does not wake the core. Only a new rising edge does.
- R10: `halt_req` while halted is ignored: `ret_ip` is not overwritten and `halted` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, also a wake event |
| halt_req | input | 1 | Halt instruction retired this cycle |
| next_ip | input | 16 | Address of the instruction after the halt |
| nmi | input | 1 | Non-maskable interrupt, edge sensitive |
| intr | input | 1 | Maskable interrupt request, level sensitive |
| if_flag | input | 1 | Interrupt-enable flag |
| halted | output | 1 | Core is in the halt state |
| bus_grant_inhibit | output | 1 | No local bus cycle may start |
| wake_pulse | output | 1 | One-cycle pulse on halt exit |
| wake_cause | output | 2 | 01 reset, 10 NMI, 11 maskable interrupt |
| ret_ip | output | 16 | Saved return pointer for interrupt entry |

## Verification
Every result comes from one register stage, so each one is due after the first rising edge that samples the stimulus. This holds for halt entry, wake, cause, pulse and the captured pointer. The bench drives inputs on the falling edge and records the expected values in a queue. The monitor pops and compares one entry a short delay after the next rising edge, so each comparison lands exactly one edge after its stimulus. The NMI cases depend on the level sampled at the previous edge, and the stimulus order sets that level up on purpose.

// File: rtl/hw_pkg.sv
package hw_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } hw_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_RESET = 2'b01,
        CAUSE_NMI   = 2'b10,
        CAUSE_INTR  = 2'b11
    } hw_cause_e;
endpackage

// File: rtl/hw_nmi_edge.sv
module hw_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi,
    output logic nmi_rise
);
    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= nmi;
    end

    assign nmi_rise = nmi & ~nmi_q;
endmodule

// File: rtl/hw_wake_arb.sv
module hw_wake_arb
    import hw_pkg::*;
(
    input  logic      rst,
    input  logic      nmi_rise,
    input  logic      intr,
    input  logic      if_flag,
    output logic      wake,
    output hw_cause_e cause
);
    always_comb begin
        if (rst)                  cause = CAUSE_RESET;
        else if (nmi_rise)        cause = CAUSE_NMI;
        else if (intr && if_flag) cause = CAUSE_INTR;
        else                      cause = CAUSE_NONE;
        wake = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hw_pkg::*;
#(
    parameter int IP_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_req,
    input  logic [IP_W-1:0] next_ip,
    input  logic            nmi,
    input  logic            intr,
    input  logic            if_flag,
    output logic            halted,
    output logic            bus_grant_inhibit,
    output logic            wake_pulse,
    output logic [1:0]      wake_cause,
    output logic [IP_W-1:0] ret_ip
);
    hw_state_e state_q, state_d;
    logic      nmi_rise, wake;
    hw_cause_e cause;

    hw_nmi_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .nmi      (nmi),
        .nmi_rise (nmi_rise)
    );

    hw_wake_arb u_arb (
        .rst      (rst),
        .nmi_rise (nmi_rise),
        .intr     (intr),
        .if_flag  (if_flag),
        .wake     (wake),
        .cause    (cause)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (halt_req) state_d = ST_HALT;
            ST_HALT: if (wake)     state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted            <= 1'b0;
            bus_grant_inhibit <= 1'b0;
            wake_pulse        <= (state_q == ST_HALT);
            wake_cause        <= CAUSE_RESET;
            ret_ip            <= '0;
        end else begin
            halted            <= (state_d == ST_HALT);
            bus_grant_inhibit <= (state_d == ST_HALT);
            wake_pulse        <= (state_q == ST_HALT) && wake;
            if (state_q == ST_HALT && wake) wake_cause <= cause;
            if (state_q == ST_RUN && halt_req) ret_ip <= next_ip;
        end
    end

    p_enter_r1: assert property (@(posedge clk) disable iff (rst)
        (!halted && halt_req) |=> (halted && ret_ip == $past(next_ip)));

    p_inhibit_r2: assert property (@(posedge clk) disable iff (rst)
        halted |-> bus_grant_inhibit);

    p_nmi_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (halted && nmi_rise) |=> (!halted && wake_cause == 2'b10));

    p_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (halted && !nmi_rise && !if_flag) |=> halted);

    p_ret_hold_r6: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(ret_ip));

    p_pulse_one_r8: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    p_pulse_exit_r8: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (!halted && $past(halted)));
endmodule

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        halt_req = 1'b0;
    logic [15:0] next_ip = '0;
    logic        nmi = 1'b0;
    logic        intr = 1'b0;
    logic        if_flag = 1'b0;
    logic        halted, bus_grant_inhibit, wake_pulse;
    logic [1:0]  wake_cause;
    logic [15:0] ret_ip;

    typedef struct {
        logic        h;
        logic        p;
        logic [1:0]  c;
        logic [15:0] r;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    halt_wake_ctrl uut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .next_ip(next_ip),
        .nmi(nmi), .intr(intr), .if_flag(if_flag),
        .halted(halted), .bus_grant_inhibit(bus_grant_inhibit),
        .wake_pulse(wake_pulse), .wake_cause(wake_cause), .ret_ip(ret_ip)
    );

    task automatic drive(input logic r, input logic hq, input logic [15:0] nip,
                         input logic n, input logic i, input logic f,
                         input logic eh, input logic ep, input logic [1:0] ec,
                         input logic [15:0] er, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; halt_req = hq; next_ip = nip; nmi = n; intr = i; if_flag = f;
        e.h = eh; e.p = ep; e.c = ec; e.r = er; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (halted !== e.h || bus_grant_inhibit !== e.h || wake_pulse !== e.p ||
                wake_cause !== e.c || ret_ip !== e.r) begin
                n_bad++;
                $display("FAIL %s: got h=%b inh=%b p=%b c=%b r=%h, want h=%b inh=%b p=%b c=%b r=%h",
                         e.tag, halted, bus_grant_inhibit, wake_pulse, wake_cause, ret_ip,
                         e.h, e.h, e.p, e.c, e.r);
            end
        end
    end

    initial begin
        // R5: reset state
        drive(1,0,16'h0000,0,0,0, 0,0,2'b01,16'h0000, "R5 reset");
        // R4: intr while running has no effect
        drive(0,0,16'h0000,0,1,1, 0,0,2'b01,16'h0000, "R4 run intr");
        // R1 R2: enter halt
        drive(0,1,16'h1234,0,0,0, 1,0,2'b01,16'h1234, "R1 enter");
        // R4: masked interrupt keeps halt
        drive(0,0,16'h0000,0,1,0, 1,0,2'b01,16'h1234, "R4 masked");
        // R10: halt_req while halted ignored
        drive(0,1,16'h5555,0,0,0, 1,0,2'b01,16'h1234, "R10 ignore");
        // R4 R6 R8: enabled interrupt wakes
        drive(0,0,16'h0000,0,1,1, 0,1,2'b11,16'h1234, "R4 R6 intr wake");
        drive(0,0,16'h0000,0,0,0, 0,0,2'b11,16'h1234, "R8 pulse ends");
        drive(0,1,16'h0200,0,0,0, 1,0,2'b11,16'h0200, "R1 enter2");
        // R3: nmi edge wakes
        drive(0,0,16'h0000,1,0,0, 0,1,2'b10,16'h0200, "R3 nmi wake");
        // R9: nmi held high into halt does not wake
        drive(0,1,16'h0300,1,0,0, 1,0,2'b10,16'h0300, "R9 enter nmi high");
        drive(0,0,16'h0000,1,0,0, 1,0,2'b10,16'h0300, "R9 held level");
        drive(0,0,16'h0000,0,0,0, 1,0,2'b10,16'h0300, "R9 nmi low");
        // R7: nmi beats intr
        drive(0,0,16'h0000,1,1,1, 0,1,2'b10,16'h0300, "R7 nmi over intr");
        drive(0,1,16'h0400,0,0,0, 1,0,2'b10,16'h0400, "R1 enter3");
        // R5 R7: reset beats all
        drive(1,0,16'h0000,1,1,1, 0,1,2'b01,16'h0000, "R5 R7 reset wake");
        drive(0,0,16'h0000,0,0,0, 0,0,2'b01,16'h0000, "R8 after reset");
        drive(0,1,16'h0500,0,0,0, 1,0,2'b01,16'h0500, "R2 enter4");
        drive(0,0,16'h0000,1,0,0, 0,1,2'b10,16'h0500, "R3 nmi wake2");
        drive(0,0,16'h0000,0,0,0, 0,0,2'b10,16'h0500, "R2 running");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule